// File: doc/BRIEF.md
# Fractional n/32 Clock Rate Scaler

This block produces a clock-enable stream whose average rate is a programmable fraction of its input clock, in steps of one thirty-second. A 5-bit scaling value `s` selects a multiplier of `32 - s`. Each 32-cycle frame then carries exactly that many enable pulses, spread as evenly as a phase accumulator allows. A value of zero gives an enable on every cycle, and the largest value gives one enable per frame.

Software reaches the block through a small register port with two 32-bit word registers. The rate register holds the scaling value. The control register holds a commit flag. A new scaling value stays pending until the commit flag is written to one. The flag then reads as busy until the new ratio has been applied at the next frame boundary, and the hardware clears it one cycle after that. While the flag is set, the scaling value is protected from writes, so the value being committed cannot change under the switch.

Top module: `frac_rate_scaler`

## Requirements
- R1: After reset both registers read 0. The output runs at the full rate, giving 32 enables in any 32-cycle window.
- R2: The rate register is at select value 0. Its scaling value occupies bits 12:8 and reads back as written while no commit is pending.
- R3: While the ratio is steady, any 32 consecutive cycles hold exactly `32 - s` enable pulses, where `s` is the applied scaling value.
- R4: Writing a new scaling value without a commit leaves the output rate unchanged.
- R5: The commit flag is bit 31 of the control register, at select value 1. Writing 1 to it sets it, and it reads 1 while the change is pending.
- R6: The commit flag clears by itself no more than 34 cycles after being set, one cycle after the new ratio is applied. From then on the output follows the new value.
- R7: While the commit flag is set, writes to bits 12:8 of the rate register are ignored. The output ratio that results from the commit is the value held when the flag was set.
- R8: All other bits of both registers are plain storage and are written normally, even while the commit flag is set. Writing 0 to bit 31 while it is set does not clear it. The self-clear of the flag leaves the other control bits intact.
- R9: A new ratio takes effect only at a frame boundary, so every frame carries pulses of a single ratio. No gap between pulses is longer than `ceil(32/m)` cycles, where `m` is the multiplier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select: 0 rate register, 1 control register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| clk_en | output | 1 | Registered clock-enable output |

## Verification
The bench sweeps scaling values that include both extremes: zero, where a design that mishandles the 32-wide multiplier would lose the always-on enable, and 31, where one pulse per frame would instead become none or two. It writes a value without a commit to catch a design that applies settings at once. It times the self-clear to catch a flag that never drops or drops before the switch. Using the single-pulse ratio to find a frame start, it writes the scaling value and clears bit 31 while a commit is pending. A design without busy protection would then commit the wrong ratio or drop the flag early, and one that masks too many bits would lose the neighbouring storage.

// File: rtl/scaler_pkg.sv
package scaler_pkg;

    localparam int unsigned DATA_W    = 32;
    localparam int unsigned SCALE_W   = 5;
    localparam int unsigned FRAME_LEN = 1 << SCALE_W;
    localparam int unsigned FIELD_LSB = 8;
    localparam int unsigned KICK_POS  = 31;

    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [SCALE_W-1:0] scale_t;
    typedef logic [SCALE_W:0]   mult_t;

    typedef enum logic {
        SEL_RATE = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic     en;
        reg_sel_e sel;
        word_t    data;
    } reg_wr_t;

    typedef struct packed {
        logic   pending;
        scale_t value;
    } commit_t;

    // pulses per frame for a given scaling value
    function automatic mult_t mult_of(scale_t s);
        return mult_t'(FRAME_LEN) - mult_t'(s);
    endfunction

endpackage

// File: rtl/scaler_regs.sv
module scaler_regs
    import scaler_pkg::*;
#(
    parameter int unsigned VAL_LSB  = FIELD_LSB,
    parameter int unsigned BUSY_BIT = KICK_POS
) (
    input  logic     clk,
    input  logic     rst,
    input  reg_wr_t  wr,
    input  reg_sel_e rd_sel,
    input  logic     switch_done,
    output word_t    rd_data,
    output commit_t  commit
);

    word_t rate_q, rate_d;
    word_t ctrl_q, ctrl_d;
    logic  busy;

    assign busy = ctrl_q[BUSY_BIT];

    always_comb begin
        rate_d = rate_q;
        if (wr.en && wr.sel == SEL_RATE) begin
            rate_d = wr.data;
            if (busy) begin
                rate_d[VAL_LSB +: SCALE_W] = rate_q[VAL_LSB +: SCALE_W];
            end
        end
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr.en && wr.sel == SEL_CTRL) begin
            ctrl_d = wr.data;
        end
        if (busy) begin
            ctrl_d[BUSY_BIT] = ~switch_done;
        end else begin
            ctrl_d[BUSY_BIT] = wr.en && (wr.sel == SEL_CTRL) && wr.data[BUSY_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rate_q <= '0;
            ctrl_q <= '0;
        end else begin
            rate_q <= rate_d;
            ctrl_q <= ctrl_d;
        end
    end

    assign rd_data        = (rd_sel == SEL_CTRL) ? ctrl_q : rate_q;
    assign commit.pending = busy;
    assign commit.value   = rate_q[VAL_LSB +: SCALE_W];

    // R7: the pending scaling value cannot move while busy
    p_value_hold_r7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(rate_q[VAL_LSB +: SCALE_W]));

    // R8: the flag is not dropped before the switch has been reported
    p_busy_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && !switch_done) |=> busy);

    // R5: writing one to the flag while idle starts a change
    p_busy_set_r5: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr.en && wr.sel == SEL_CTRL && wr.data[BUSY_BIT]) |=> busy);

    // R6: completion is only reported while a change is pending
    p_done_when_busy_r6: assert property (@(posedge clk) disable iff (rst)
        switch_done |-> busy);

endmodule

// File: rtl/scaler_pulse_gen.sv
module scaler_pulse_gen
    import scaler_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  commit_t commit,
    output logic    clk_en,
    output logic    switch_done
);

    localparam int unsigned SUM_W = SCALE_W + 1;

    scale_t             active_q;
    logic [SCALE_W-1:0] phase_q;
    logic [SCALE_W-1:0] acc_q;
    logic               en_q;
    logic               done_q;

    logic [SUM_W-1:0]   sum;
    logic               carry;
    logic               frame_end;
    logic               apply;

    assign sum       = SUM_W'(acc_q) + mult_of(active_q);
    assign carry     = sum[SCALE_W];
    assign frame_end = &phase_q;
    assign apply     = frame_end && commit.pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
            phase_q  <= '0;
            acc_q    <= '0;
            en_q     <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            phase_q <= phase_q + 1'b1;
            acc_q   <= sum[SCALE_W-1:0];
            en_q    <= carry;
            done_q  <= apply;
            if (apply) begin
                active_q <= commit.value;
            end
        end
    end

    assign clk_en      = en_q;
    assign switch_done = done_q;

    // pulses seen so far in the current frame (checking only)
    logic [SCALE_W:0] seen_q;
    always_ff @(posedge clk) begin
        if (rst || frame_end) seen_q <= '0;
        else                  seen_q <= seen_q + {{SCALE_W{1'b0}}, carry};
    end

    // R3: the accumulator is back at zero whenever a frame starts
    p_acc_align_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == '0) |-> (acc_q == '0));

    // R3: each frame carries exactly the multiplier's count of pulses
    p_frame_count_r3: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> ((seen_q + {{SCALE_W{1'b0}}, carry}) == mult_of(active_q)));

    // R9: the applied ratio changes only at a frame boundary with a commit
    p_switch_boundary_r9: assert property (@(posedge clk) disable iff (rst)
        !apply |=> $stable(active_q));

    // R6: completion follows the frame boundary by one cycle
    p_done_timing_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> (phase_q == '0));

endmodule

// File: rtl/frac_rate_scaler.sv
module frac_rate_scaler
    import scaler_pkg::*;
#(
    parameter int unsigned VAL_LSB  = FIELD_LSB,
    parameter int unsigned BUSY_BIT = KICK_POS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              clk_en
);

    localparam int unsigned FIELD_TOP = VAL_LSB + SCALE_W;

    initial begin
        if (FIELD_TOP > DATA_W || BUSY_BIT >= DATA_W ||
            (BUSY_BIT >= VAL_LSB && BUSY_BIT < FIELD_TOP)) begin
            $error("frac_rate_scaler: field placement out of range");
        end
    end

    reg_wr_t  wr_s;
    reg_sel_e sel_s;
    commit_t  commit_s;
    logic     done_s;

    assign sel_s = reg_sel_e'(reg_sel);

    always_comb begin
        wr_s.en   = reg_wr;
        wr_s.sel  = sel_s;
        wr_s.data = reg_wdata;
    end

    scaler_regs #(
        .VAL_LSB  (VAL_LSB),
        .BUSY_BIT (BUSY_BIT)
    ) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr_s),
        .rd_sel      (sel_s),
        .switch_done (done_s),
        .rd_data     (reg_rdata),
        .commit      (commit_s)
    );

    scaler_pulse_gen u_gen (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit_s),
        .clk_en      (clk_en),
        .switch_done (done_s)
    );

endmodule

// File: tb/sim_frac_rate_scaler.sv
`timescale 1ns/1ps
module sim_frac_rate_scaler;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        clk_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    frac_rate_scaler u0 (
        .clk       (clk),
        .rst       (rst),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .clk_en    (clk_en)
    );

    localparam int NVEC = 8;
    localparam logic [4:0] VEC_VAL [NVEC] = '{5'd0, 5'd1, 5'd5, 5'd16, 5'd17, 5'd24, 5'd30, 5'd31};
    localparam int         VEC_EXP [NVEC] = '{32, 31, 27, 16, 15, 8, 2, 1};

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic write_reg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic wait_clear(output int cyc);
        logic [31:0] d;
        cyc = 0;
        for (int i = 0; i < 40; i++) begin
            read_reg(1'b1, d);
            cyc++;
            if (!d[31]) break;
        end
    endtask

    task automatic count_window(input int n, output int cnt, output int gap);
        int run;
        cnt = 0; gap = 0; run = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_en) begin cnt++; run = 0; end
            else begin run++; if (run > gap) gap = run; end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int cnt, gap, cyc, m;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_reg(1'b0, d); check(d == 32'h0, "R1 rate reg reset", d, 0);
        read_reg(1'b1, d); check(d == 32'h0, "R1 ctrl reg reset", d, 0);
        count_window(32, cnt, gap); check(cnt == 32, "R1 full rate after reset", cnt, 32);

        // table walk: R2 R3 R5 R6 R9
        for (int v = 0; v < NVEC; v++) begin
            m = VEC_EXP[v];
            write_reg(1'b0, {8'h5A, 8'hC3, 3'b101, VEC_VAL[v], 8'h96 ^ 8'(v)});
            read_reg(1'b0, d);
            check(d[12:8] == VEC_VAL[v], "R2 value readback", d[12:8], VEC_VAL[v]);
            write_reg(1'b1, 32'h8000_0000 | 32'(v));
            read_reg(1'b1, d);
            check(d[31] == 1'b1, "R5 flag reads busy", d[31], 1);
            wait_clear(cyc);
            check(cyc < 40, "R6 flag self-clears", cyc, 34);
            read_reg(1'b1, d);
            check(d == 32'(v), "R8 ctrl storage after clear", d, v);
            count_window(64, cnt, gap);
            check(cnt == 2 * m, "R3 pulses per 64 cycles", cnt, 2 * m);
            check(gap <= (32 + m - 1) / m - 1, "R9 pulse spread", gap, (32 + m - 1) / m - 1);
        end

        // R4: value written without a commit has no effect (active ratio is 1/32)
        write_reg(1'b0, 32'h0000_0000);
        repeat (40) @(negedge clk);
        count_window(64, cnt, gap);
        check(cnt == 2, "R4 no change without commit", cnt, 2);

        // R7 R8: align to frame start via the single pulse, then commit 31 again
        write_reg(1'b0, 32'h0000_1F00);
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!clk_en && cyc < 40);
        write_reg(1'b1, 32'h8000_0000);
        write_reg(1'b0, 32'h1234_03AB);
        read_reg(1'b0, d);
        check(d[12:8] == 5'd31, "R7 value write ignored while busy", d[12:8], 31);
        check({d[31:13], d[7:0]} == {19'h091A0, 8'hAB}, "R8 other rate bits stored while busy",
              {d[31:13], d[7:0]}, {19'h091A0, 8'hAB});
        write_reg(1'b1, 32'h0000_0077);
        read_reg(1'b1, d);
        check(d == 32'h8000_0077, "R8 zero to flag ignored while busy", d, 32'h8000_0077);
        wait_clear(cyc);
        check(cyc < 40, "R6 flag clears after busy writes", cyc, 34);
        read_reg(1'b1, d);
        check(d == 32'h0000_0077, "R8 ctrl low bits kept by self-clear", d, 32'h77);
        count_window(64, cnt, gap);
        check(cnt == 2, "R7 committed ratio is the protected value", cnt, 2);

        // R6 R3: commit full rate from the slowest ratio
        write_reg(1'b0, 32'h0000_0000);
        write_reg(1'b1, 32'h8000_0000);
        wait_clear(cyc);
        check(cyc < 40, "R6 flag clears at full rate switch", cyc, 34);
        count_window(32, cnt, gap);
        check(cnt == 32, "R3 full rate after switch", cnt, 32);

        // R1: reset again restores defaults
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk); rst = 1'b0;
        read_reg(1'b1, d); check(d == 32'h0, "R1 ctrl cleared by reset", d, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule